// File: doc/BRIEF.md
# Lookup-Table Binary Neuron

This block is a single neuron of a fully unrolled binarized layer. Each of its synapses is not a weight combined with an input by XNOR. It is a small programmable Boolean function: a truth table of 2^K one-bit entries, addressed by a K-bit tuple that is gathered from the N-bit input vector through per-synapse index fields. Binary values stand for -1 (logic 0) and +1 (logic 1).

The neuron sums the ±1 outputs of all enabled synapses. It adds a signed threshold offset to that sum and emits the sign as a binary output. A pruned synapse, one whose enable bit is clear, counts neither as a +1 nor as a -1. The block accepts one input vector every clock and answers three cycles later. There is no time multiplexing: every synapse has its own lookup hardware.

Truth tables, selection indices and enables are loaded through a configuration write port that addresses one synapse per write. The threshold has a write strobe of its own.

Top module: `lut_neuron`

## Requirements
- R1: Logic 0 means -1 and logic 1 means +1. The output is 1 when (2·ones − active + thr) ≥ 0, where ones is the number of enabled synapses that output 1 and active is the number of enabled synapses. An exact zero therefore gives 1.
- R2: For a synapse, address bit j is the input bit selected by select field j, with field 0 driving the address LSB. The synapse output is bit [address] of its 16-entry truth table.
- R3: A select write stores cfg_data[6*j +: 6] as the input index of tuple position j. Several fields, or several synapses, may name the same input bit.
- R4: A synapse whose enable bit is 0 adds nothing to ones and nothing to active, whatever its truth table and indices hold.
- R5: With every synapse pruned, the output is 1 for any input when thr = 0, and 0 when thr = -1.
- R6: thr is an 8-bit two's-complement offset, loaded when thr_we is high, and is added to the ±1 sum before the sign test.
- R7: out_valid follows in_valid exactly three clock edges later. A new vector is accepted every cycle, and bubbles in in_valid appear as the same bubbles in out_valid.
- R8: When cfg_we is high, cfg_kind 0 writes the truth table (cfg_data[15:0]) of synapse cfg_idx and cfg_kind 1 writes its select fields. Either kind also writes cfg_en into that synapse's enable bit, and a write leaves the other kind's contents of that synapse untouched. A write is in force for the next vector.
- R9: After reset every synapse is pruned, thr is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is valid |
| in_vec | input | 64 | Binary input vector |
| cfg_we | input | 1 | Synapse configuration write strobe |
| cfg_kind | input | 1 | 0 = truth table, 1 = select fields |
| cfg_idx | input | 4 | Synapse addressed by the write |
| cfg_data | input | 24 | Truth table or packed select fields |
| cfg_en | input | 1 | Enable bit written with every synapse write |
| thr_we | input | 1 | Threshold write strobe |
| thr_data | input | 8 | Signed threshold offset |
| out_valid | output | 1 | Output is valid |
| out_bit | output | 1 | Neuron output (1 = +1, 0 = -1) |

## Verification
The bench builds the block with its defaults: N = 64 inputs, M = 16 synapses and K = 4. Sixteen synapses give a popcount range wide enough to reach exact ties, all-pruned and fully enabled layers in one stream. Selection indices reach bit 63 of the input, so the high end of the index field is tested too. With an 8-bit threshold, offsets both large enough and small enough to flip the sign are in reach.

// File: rtl/lut_neuron.sv
module lut_neuron #(
  parameter int N     = 64,
  parameter int M     = 16,
  parameter int K     = 4,
  parameter int THR_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [N-1:0]                          in_vec,
  input  logic                                  cfg_we,
  input  logic                                  cfg_kind,
  input  logic [((M > 1) ? $clog2(M) : 1)-1:0]  cfg_idx,
  input  logic [(((1 << K) > K*$clog2(N)) ? (1 << K) : K*$clog2(N))-1:0] cfg_data,
  input  logic                                  cfg_en,
  input  logic                                  thr_we,
  input  logic [THR_W-1:0]                      thr_data,
  output logic                                  out_valid,
  output logic                                  out_bit
);
  localparam int SW   = $clog2(N);
  localparam int TT   = 1 << K;
  localparam int SELW = K * SW;
  localparam int CW   = $clog2(M + 1);
  localparam int EW   = ((CW + 2 > THR_W) ? CW + 2 : THR_W) + 1;

  logic [M-1:0][TT-1:0]   tt_q;
  logic [M-1:0][SELW-1:0] sel_q;
  logic [M-1:0]           en_q;
  logic [THR_W-1:0]       thr_q;

  logic [N-1:0]  in_r;
  logic          v1, v2;
  logic [M-1:0]  hit;
  logic [CW-1:0] cnt_n, act_n, cnt_r, act_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tt_q  <= '0;
      sel_q <= '0;
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_kind) sel_q[cfg_idx] <= cfg_data[SELW-1:0];
        else          tt_q[cfg_idx]  <= cfg_data[TT-1:0];
        en_q[cfg_idx] <= cfg_en;
      end
      if (thr_we) thr_q <= thr_data;
    end
  end

  for (genvar m = 0; m < M; m++) begin : g_syn
    logic [K-1:0] addr;
    for (genvar j = 0; j < K; j++) begin : g_tap
      assign addr[j] = in_r[sel_q[m][j*SW +: SW]];
    end
    assign hit[m] = en_q[m] & tt_q[m][addr];
  end

  always_comb begin
    cnt_n = '0;
    act_n = '0;
    for (int i = 0; i < M; i++) begin
      cnt_n = cnt_n + CW'(hit[i]);
      act_n = act_n + CW'(en_q[i]);
    end
  end

  wire signed [EW-1:0] two_cnt = {{(EW-CW-1){1'b0}}, cnt_r, 1'b0};
  wire signed [EW-1:0] act_s   = {{(EW-CW){1'b0}}, act_r};
  wire signed [EW-1:0] thr_s   = {{(EW-THR_W){thr_q[THR_W-1]}}, thr_q};
  wire signed [EW-1:0] score   = two_cnt - act_s + thr_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_r      <= '0;
      v1        <= 1'b0;
      v2        <= 1'b0;
      cnt_r     <= '0;
      act_r     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      in_r      <= in_vec;
      v1        <= in_valid;
      cnt_r     <= cnt_n;
      act_r     <= act_n;
      v2        <= v1;
      out_valid <= v2;
      out_bit   <= ~score[EW-1];
    end
  end
endmodule

// File: rtl/lut_neuron_chk.sv
module lut_neuron_chk #(
  parameter int N = 64,
  parameter int M = 16,
  parameter int K = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  in_valid,
  input logic                                  out_valid,
  input logic                                  cfg_we,
  input logic                                  cfg_kind,
  input logic [((M > 1) ? $clog2(M) : 1)-1:0]  cfg_idx,
  input logic [(((1 << K) > K*$clog2(N)) ? (1 << K) : K*$clog2(N))-1:0] cfg_data,
  input logic                                  cfg_en,
  input logic [M-1:0][(1 << K)-1:0]            tt_q,
  input logic [M-1:0][K*$clog2(N)-1:0]         sel_q,
  input logic [M-1:0]                          en_q,
  input logic [$clog2(M+1)-1:0]                cnt_r,
  input logic [$clog2(M+1)-1:0]                act_r
);
  localparam int TT   = 1 << K;
  localparam int SELW = K * $clog2(N);

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r <= act_r);

  assert_table_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_kind) |=> (tt_q[$past(cfg_idx)] == $past(cfg_data[TT-1:0])));

  assert_select_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind) |=> (sel_q[$past(cfg_idx)] == $past(cfg_data[SELW-1:0])));

  assert_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q[$past(cfg_idx)] == $past(cfg_en)));
endmodule

bind lut_neuron lut_neuron_chk #(.N(N), .M(M), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
  .cfg_en(cfg_en), .tt_q(tt_q), .sel_q(sel_q), .en_q(en_q),
  .cnt_r(cnt_r), .act_r(act_r)
);

// File: tb/sim_lut_neuron.sv
module sim_lut_neuron;
  localparam int N = 64, M = 16, K = 4, SW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] in_vec = '0;
  logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_en = 1'b0, thr_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [23:0] cfg_data = '0;
  logic [7:0] thr_data = '0;
  logic out_valid, out_bit;

  int checks = 0, errors = 0;

  logic [15:0] m_tt [M];
  logic [23:0] m_sel [M];
  logic        m_en [M];
  int          m_thr;

  logic [N-1:0] s_vec [64];
  logic         s_vld [64];

  always #4 clk = ~clk;

  lut_neuron u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cfg_en(cfg_en), .thr_we(thr_we), .thr_data(thr_data),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  function automatic logic model(logic [N-1:0] v);
    int ones = 0, act = 0;
    for (int m = 0; m < M; m++) begin
      if (m_en[m]) begin
        logic [3:0] a;
        for (int j = 0; j < K; j++) a[j] = v[m_sel[m][j*SW +: SW]];
        ones += int'(m_tt[m][a]);
        act++;
      end
    end
    return (2*ones - act + m_thr) >= 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg_write(int idx, logic kind, logic [23:0] data, logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_kind = kind; cfg_data = data; cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
    if (kind) m_sel[idx] = data; else m_tt[idx] = data[15:0];
    m_en[idx] = en;
  endtask

  task automatic thr_write(int v);
    @(negedge clk);
    thr_we = 1'b1; thr_data = 8'(v);
    @(negedge clk);
    thr_we = 1'b0;
    m_thr = v;
  endtask

  task automatic run_stream(int cnt, string req);
    logic exp [64];
    for (int i = 0; i < cnt; i++) exp[i] = model(s_vec[i]);
    for (int cyc = 0; cyc < cnt + 4; cyc++) begin
      @(negedge clk);
      if (cyc >= 3) begin
        if (cyc - 3 < cnt) begin
          check({req, " valid"}, out_valid, s_vld[cyc-3]);
          if (s_vld[cyc-3]) check({req, " out"}, out_bit, exp[cyc-3]);
        end else check({req, " valid drop"}, out_valid, 1'b0);
      end
      in_valid = (cyc < cnt) ? s_vld[cyc] : 1'b0;
      in_vec   = (cyc < cnt) ? s_vec[cyc] : '0;
    end
  endtask

  task automatic fill_random(int cnt, bit gaps);
    for (int i = 0; i < cnt; i++) begin
      s_vec[i] = {$urandom, $urandom};
      s_vld[i] = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 reset valid", out_valid, 1'b0);
    fill_random(6, 0);
    run_stream(6, "R9 reset state all pruned");
  endtask

  task automatic t_tie;
    cfg_write(0, 1'b0, 24'h00FFFF, 1'b1);
    cfg_write(1, 1'b0, 24'h000000, 1'b1);
    fill_random(4, 0);
    run_stream(4, "R1 zero sum tie");
    thr_write(-1);
    run_stream(4, "R6 tie with thr -1");
    cfg_write(2, 1'b0, 24'h00FFFF, 1'b1);
    run_stream(4, "R6 sum +1 with thr -1");
    thr_write(0);
  endtask

  task automatic t_pruned;
    for (int m = 0; m < M; m++) cfg_write(m, 1'b0, 24'($urandom), 1'b0);
    fill_random(4, 0);
    run_stream(4, "R5 all pruned thr 0");
    thr_write(-1);
    for (int i = 0; i < 4; i++) s_vec[i] = '1;
    run_stream(4, "R5 all pruned thr -1");
    thr_write(0);
  endtask

  task automatic t_lookup;
    cfg_write(0, 1'b1, {6'd63, 6'd20, 6'd10, 6'd3}, 1'b1);
    cfg_write(0, 1'b0, 24'h000100, 1'b1);
    s_vec[0] = 64'h8000_0000_0000_0000; s_vld[0] = 1;
    s_vec[1] = 64'h8000_0000_0010_0000; s_vld[1] = 1;
    s_vec[2] = 64'h0000_0000_0000_0008; s_vld[2] = 1;
    s_vec[3] = 64'h0;                   s_vld[3] = 1;
    run_stream(4, "R2 addr from fields bit63 msb");
    cfg_write(0, 1'b1, {6'd5, 6'd5, 6'd5, 6'd5}, 1'b1);
    cfg_write(0, 1'b0, 24'h008000, 1'b1);
    cfg_write(1, 1'b1, {6'd5, 6'd5, 6'd5, 6'd5}, 1'b1);
    cfg_write(1, 1'b0, 24'h008000, 1'b1);
    s_vec[0] = 64'h20; s_vec[1] = 64'h0; s_vec[2] = 64'hFFDF; s_vec[3] = 64'h21;
    run_stream(4, "R3 repeated index");
    check("R3 repeated index bit5 set", model(64'h20), 1'b1);
    check("R3 repeated index bit5 clear", model(64'h0), 1'b0);
  endtask

  task automatic t_cfg;
    for (int m = 0; m < M; m++) cfg_write(m, 1'b0, 24'h0, 1'b0);
    cfg_write(4, 1'b0, 24'h00FFFF, 1'b1);
    cfg_write(4, 1'b1, 24'($urandom), 1'b1);
    fill_random(4, 0);
    run_stream(4, "R8 select write keeps table");
    cfg_write(5, 1'b0, 24'h000000, 1'b1);
    cfg_write(6, 1'b0, 24'h000000, 1'b1);
    run_stream(4, "R8 new synapses in force");
    cfg_write(6, 1'b1, 24'($urandom), 1'b0);
    run_stream(4, "R4 select write prunes");
  endtask

  task automatic t_random(int rounds, bit gaps);
    for (int r = 0; r < rounds; r++) begin
      for (int m = 0; m < M; m++) begin
        cfg_write(m, 1'b1, 24'($urandom), 1'b1);
        cfg_write(m, 1'b0, 24'($urandom), ($urandom_range(0, 2) != 0));
      end
      thr_write($urandom_range(0, 8) - 4);
      fill_random(40, gaps);
      run_stream(40, gaps ? "R7 random with bubbles" : "R4 random masks");
    end
  endtask

  initial begin
    for (int m = 0; m < M; m++) begin m_tt[m] = '0; m_sel[m] = '0; m_en[m] = 1'b0; end
    m_thr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_tie;
    t_pruned;
    t_lookup;
    t_cfg;
    t_random(6, 0);
    t_random(6, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule